// File: doc/BRIEF.md
# Prioritized vectored interrupt controller

This block gathers up to 64 edge-triggered interrupt sources and presents one request, with the number of the source that won, to a processor core. Each source owns a control byte on a byte-wide register bus. The byte holds a pending flag, a mask bit and a 3-bit priority level. The same mask bits can also be read and written as packed mask bytes, eight sources to a byte. An in-service byte records which priority levels the core is currently handling.

A rising edge on a source input latches its pending flag. The flag is latched even while the source is masked, so the request is delivered later when the source is unmasked, unless software clears the flag first. Among the pending, unmasked sources, the block forwards the one with the numerically lowest level; a tie goes to the lowest source number. A source is forwarded only if its level is strictly better than every level in service. An acknowledge takes the winner into service. An end-of-interrupt strobe retires the most urgent level in service.

Top module: `prio_intc`

## Requirements
- R1: After reset every control byte reads 0x47 (masked, not pending, priority 7). Every packed mask byte reads 0xFF, the in-service byte reads 0x00 and irq_o is low.
- R2: A rising edge on src_i[n] sets the pending flag of source n one clock later, whether or not the source is masked. A source held high does not set the flag again.
- R3: The control byte of source n is at byte address 2n. Bit 7 is the pending flag, bit 6 is the mask (1 = masked) and bits 2:0 are the priority. Bits 5:3 read 0. Writing bit 7 as 0 clears the pending flag and writing it as 1 sets it.
- R4: The packed mask bytes are at 0x80 + (n>>3), with source n at bit n&7 (1 = masked). They share storage with bit 6 of the control bytes, so a write through either view shows in both.
- R5: irq_o is high exactly when some source is pending, unmasked and below the in-service ceiling. irq_id_o names the source with the lowest priority value, and on a tie the lowest source number.
- R6: A high ack_i while irq_o is high clears the pending flag of irq_id_o and sets the in-service bit of its level on the next clock. An ack_i while irq_o is low has no effect.
- R7: The in-service byte at address 0x90 has bit k set while level k is in service. When any bit is set, sources whose level is equal to or greater than the lowest set index are held back.
- R8: eoi_i clears the lowest-index set in-service bit on the next clock. With no bit set it has no effect.
- R9: An edge that arrives in the same clock as a software clear, or as an acknowledge of the same source, leaves the pending flag set.
- R10: Odd addresses below 0x80 and all other unmapped addresses read 0x00. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Source request lines, rising-edge sensitive |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Register write data |
| we_i | input | 1 | Register write strobe |
| rdata_o | output | 8 | Register read data, combinational from addr_i |
| irq_o | output | 1 | Request to the core |
| irq_id_o | output | 6 | Number of the winning source |
| ack_i | input | 1 | Core accepts the current request |
| eoi_i | input | 1 | Core finished the most urgent level in service |

## Verification
All state changes take effect on the one rising clock edge after the stimulus: edges on src_i, register writes, acknowledge and end-of-interrupt. The outputs irq_o, irq_id_o and rdata_o are combinational from that state and from addr_i. The bench therefore applies each stimulus on a falling edge and removes it on the next falling edge, which puts exactly one rising edge in between. It then samples one time step after that falling edge, so each result is read in the first cycle it is due. The same-cycle collisions of R9 are driven on a single falling edge, so that both events land on the same rising edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int PEND_BIT = 7;
  localparam int MASK_BIT = 6;
endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MASK_BASE = 8'h80,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_SRC-1:0]               src_i,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [7:0]                       wdata_i,
  input  logic                             ack_vld_i,
  input  logic [ID_W-1:0]                  ack_id_i,
  output logic [NUM_SRC-1:0]               pend_o,
  output logic [NUM_SRC-1:0]               mask_o,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_o
);
  import intc_pkg::*;

  logic [NUM_SRC-1:0] src_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(2 * i);
    localparam logic [ADDR_W-1:0] MASK_A = MASK_BASE + ADDR_W'(i / 8);
    logic rise, ctrl_hit, mask_hit, ack_hit;

    assign rise     = src_i[i] & ~src_q[i];
    assign ctrl_hit = we_i && (addr_i == CTRL_A);
    assign mask_hit = we_i && (addr_i == MASK_A);
    assign ack_hit  = ack_vld_i && (ack_id_i == ID_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q[i]  <= 1'b0;
        pend_o[i] <= 1'b0;
        mask_o[i] <= 1'b1;
        prio_o[i] <= '1;
      end else begin
        src_q[i] <= src_i[i];
        if (ctrl_hit) begin
          pend_o[i] <= wdata_i[PEND_BIT] | rise;
          mask_o[i] <= wdata_i[MASK_BIT];
          prio_o[i] <= wdata_i[PRIO_W-1:0];
        end else begin
          pend_o[i] <= (pend_o[i] & ~ack_hit) | rise;
          if (mask_hit) mask_o[i] <= wdata_i[i % 8];
        end
      end
    end

    p_edge_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_i[i] && !src_q[i]) |=> pend_o[i]);
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W = 3,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_SRC-1:0]               pend_i,
  input  logic [NUM_SRC-1:0]               mask_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_i,
  input  logic [PRIO_W:0]                  ceiling_i,
  output logic                             irq_o,
  output logic [ID_W-1:0]                  id_o,
  output logic [PRIO_W-1:0]                lvl_o
);
  // descending scan with <= keeps the lowest index on equal level
  always_comb begin
    irq_o = 1'b0;
    id_o  = '0;
    lvl_o = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i] && !mask_i[i] && ({1'b0, prio_i[i]} < ceiling_i) &&
          (!irq_o || prio_i[i] <= lvl_o)) begin
        irq_o = 1'b1;
        id_o  = ID_W'(i);
        lvl_o = prio_i[i];
      end
    end
  end

  p_winner_live_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_i[id_o] && !mask_i[id_o]));
  p_below_ceiling_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ({1'b0, prio_i[id_o]} < ceiling_i));
endmodule

// File: rtl/intc_inservice.sv
module intc_inservice #(
  parameter int PRIO_LVLS = 8,
  localparam int PRIO_W = $clog2(PRIO_LVLS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ack_vld_i,
  input  logic [PRIO_W-1:0]     ack_lvl_i,
  input  logic                  eoi_i,
  output logic [PRIO_LVLS-1:0]  isr_o,
  output logic [PRIO_W:0]       ceiling_o
);
  logic [PRIO_LVLS-1:0] lowest, set_vec;

  assign lowest  = isr_o & (~isr_o + PRIO_LVLS'(1));
  assign set_vec = ack_vld_i ? (PRIO_LVLS'(1) << ack_lvl_i) : '0;

  always_comb begin
    ceiling_o = (PRIO_W + 1)'(PRIO_LVLS);
    for (int k = PRIO_LVLS - 1; k >= 0; k--)
      if (isr_o[k]) ceiling_o = (PRIO_W + 1)'(k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_o <= '0;
    else         isr_o <= (isr_o & ~(eoi_i ? lowest : '0)) | set_vec;
  end

  p_ack_enters_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vld_i |=> isr_o[$past(ack_lvl_i)]);
  p_eoi_retires_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_vld_i && (|isr_o)) |=>
      ($countones(isr_o) + 1 == $countones($past(isr_o))));
  p_eoi_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_vld_i && !(|isr_o)) |=> !(|isr_o));
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_LVLS = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MASK_BASE = 8'h80,
  parameter logic [ADDR_W-1:0] ISR_ADDR = 8'h90,
  localparam int PRIO_W = $clog2(PRIO_LVLS),
  localparam int ID_W = $clog2(NUM_SRC),
  localparam int MASK_BYTES = NUM_SRC / 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         wdata_i,
  input  logic               we_i,
  output logic [7:0]         rdata_o,
  output logic               irq_o,
  output logic [ID_W-1:0]    irq_id_o,
  input  logic               ack_i,
  input  logic               eoi_i
);
  import intc_pkg::*;

  logic [NUM_SRC-1:0]             pend, mask;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
  logic [PRIO_LVLS-1:0]           isr;
  logic [PRIO_W:0]                ceiling;
  logic [PRIO_W-1:0]              win_lvl;
  logic                           ack_vld;

  assign ack_vld = ack_i & irq_o;

  intc_src_bank #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .MASK_BASE(MASK_BASE)
  ) u_bank (
    .clk_i, .rst_ni, .src_i, .we_i, .addr_i, .wdata_i,
    .ack_vld_i(ack_vld), .ack_id_i(irq_id_o),
    .pend_o(pend), .mask_o(mask), .prio_o(prio)
  );

  intc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk_i, .rst_ni, .pend_i(pend), .mask_i(mask), .prio_i(prio),
    .ceiling_i(ceiling), .irq_o, .id_o(irq_id_o), .lvl_o(win_lvl)
  );

  intc_inservice #(.PRIO_LVLS(PRIO_LVLS)) u_isr (
    .clk_i, .rst_ni, .ack_vld_i(ack_vld), .ack_lvl_i(win_lvl), .eoi_i,
    .isr_o(isr), .ceiling_o(ceiling)
  );

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (addr_i == ADDR_W'(2 * i)) begin
        rdata_o[PEND_BIT]       = pend[i];
        rdata_o[MASK_BIT]       = mask[i];
        rdata_o[PRIO_W-1:0]     = prio[i];
      end
    end
    for (int b = 0; b < MASK_BYTES; b++)
      if (addr_i == MASK_BASE + ADDR_W'(b)) rdata_o = mask[b*8 +: 8];
    if (addr_i == ISR_ADDR) rdata_o = 8'(isr);
  end

  p_isr_onehot_on_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_vld && !eoi_i) |=> ($countones(isr) == $countones($past(isr)) + 1));
endmodule

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic [7:0]  addr = '0, wdata = '0;
  logic        we = 1'b0, ack = 1'b0, eoi = 1'b0;
  logic [7:0]  rdata;
  logic        irq;
  logic [5:0]  irq_id;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_intc dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .rdata_o(rdata), .irq_o(irq), .irq_id_o(irq_id),
    .ack_i(ack), .eoi_i(eoi)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; #1;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic pulse_src(int n);
    @(negedge clk); src[n] = 1'b1;
    @(negedge clk); src[n] = 1'b0; #1;
  endtask

  task automatic strobe_ack;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0; #1;
  endtask

  task automatic strobe_eoi;
    @(negedge clk); eoi = 1'b1;
    @(negedge clk); eoi = 1'b0; #1;
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl0", 8'h00, 8'h47);
    rd_chk("R1 ctrl63", 8'd126, 8'h47);
    rd_chk("R1 mask0", 8'h80, 8'hFF);
    rd_chk("R1 mask7", 8'h87, 8'hFF);
    rd_chk("R1 isr", 8'h90, 8'h00);
    check("R1 irq", 8'(irq), 8'h0);
  endtask

  task automatic t_edge_masked;
    pulse_src(5);
    rd_chk("R2 masked edge pends", 8'd10, 8'hC7);
    check("R2 masked no irq", 8'(irq), 8'h0);
    wr(8'd10, 8'h47);
    rd_chk("R3 sw clear", 8'd10, 8'h47);
    @(negedge clk); src[5] = 1'b1;
    @(negedge clk); #1;
    wr(8'd10, 8'h47);
    repeat (3) @(negedge clk);
    #1;
    rd_chk("R2 held level no retrigger", 8'd10, 8'h47);
    @(negedge clk); src[5] = 1'b0;
    pulse_src(5);
    rd_chk("R2 new edge pends", 8'd10, 8'hC7);
  endtask

  task automatic t_mask_views;
    wr(8'h80, 8'hDF);
    rd_chk("R4 packed->ctrl", 8'd10, 8'h87);
    wr(8'd18, 8'h03);
    rd_chk("R4 ctrl->packed", 8'h81, 8'hFD);
    wr(8'd80, 8'hFF);
    rd_chk("R3 bits5:3 read zero", 8'd80, 8'hC7);
  endtask

  task automatic t_arbitrate;
    check("R5 irq src5", 8'(irq), 8'h1);
    check("R5 id src5", 8'(irq_id), 8'd5);
    pulse_src(9);
    check("R5 better level wins", 8'(irq_id), 8'd9);
    wr(8'd24, 8'h83);
    rd_chk("R3 sw set", 8'd24, 8'h83);
    check("R5 tie lowest index", 8'(irq_id), 8'd9);
    wr(8'h81, 8'hEF);
    check("R5 masked loses", 8'(irq_id), 8'd12);
  endtask

  task automatic t_nesting;
    strobe_ack;
    rd_chk("R6 isr level3", 8'h90, 8'h08);
    rd_chk("R6 pend cleared", 8'd24, 8'h03);
    check("R7 lower level held", 8'(irq), 8'h0);
    strobe_ack;
    rd_chk("R6 ack ignored", 8'h90, 8'h08);
    wr(8'd26, 8'h83);
    check("R7 equal level held", 8'(irq), 8'h0);
    wr(8'd40, 8'h81);
    check("R7 nested irq", 8'(irq), 8'h1);
    check("R7 nested id", 8'(irq_id), 8'd20);
    strobe_ack;
    rd_chk("R6 isr nested", 8'h90, 8'h0A);
    check("R7 all held", 8'(irq), 8'h0);
  endtask

  task automatic t_eoi;
    strobe_eoi;
    rd_chk("R8 retire level1", 8'h90, 8'h08);
    check("R8 still held", 8'(irq), 8'h0);
    strobe_eoi;
    rd_chk("R8 retire level3", 8'h90, 8'h00);
    check("R8 released id", 8'(irq_id), 8'd13);
    strobe_eoi;
    rd_chk("R8 empty eoi", 8'h90, 8'h00);
    check("R8 empty eoi irq", 8'(irq), 8'h1);
  endtask

  task automatic t_collide;
    @(negedge clk); src[30] = 1'b1; addr = 8'd60; wdata = 8'h47; we = 1'b1;
    @(negedge clk); we = 1'b0; src[30] = 1'b0; #1;
    rd_chk("R9 edge beats sw clear", 8'd60, 8'hC7);
    check("R9 irq id before ack", 8'(irq_id), 8'd13);
    @(negedge clk); src[13] = 1'b1; ack = 1'b1;
    @(negedge clk); src[13] = 1'b0; ack = 1'b0; #1;
    rd_chk("R9 edge beats ack", 8'd26, 8'h83);
    rd_chk("R9 ack took level3", 8'h90, 8'h08);
    strobe_eoi;
  endtask

  task automatic t_unmapped;
    rd_chk("R10 odd addr", 8'd1, 8'h00);
    wr(8'd3, 8'hFF);
    rd_chk("R10 odd write ignored", 8'd2, 8'h47);
    rd_chk("R10 odd read", 8'd3, 8'h00);
    wr(8'h88, 8'h00);
    rd_chk("R10 gap read", 8'h88, 8'h00);
    rd_chk("R10 gap write ignored", 8'h87, 8'hFF);
    rd_chk("R10 past isr", 8'h91, 8'h00);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_edge_masked();
    t_mask_views();
    t_arbitrate();
    t_nesting();
    t_eoi();
    t_collide();
    t_unmapped();
    finish_run();
  end
endmodule